// File: doc/BRIEF.md
# Framed Serial Register Write Port

This block receives register writes over a three-wire serial link (serial clock, serial data, active-low select) and presents the contents of three write-only control registers as parallel outputs. The serial pins are brought into the system clock domain through synchronizer stages, and rising edges of the serial clock are found by oversampling. A write is a fixed 32-bit frame sent most significant bit first. It carries a 12-bit alignment header, a 4-bit register address and a 16-bit value.

Frame boundaries come from the header pattern and a bit counter, not from the select line. Frames may follow each other with no gap while select stays low. A frame whose header is wrong makes the receiver ignore all later traffic until select is released. A mode input enables the whole port. While the mode input is low, the port does nothing. Each completed write to a mapped register updates that register and raises a one-cycle strobe that carries the address.

Top module: `serial_regport`

## Requirements
- R1: After reset, `cfg_reg` is CFG_DEFAULT (16'h00C0), `ofs_reg` is 16'h0000, `fs_reg` is the midscale code 16'h8000, and `wr_stb` is low.
- R2: A frame is 32 bits sampled on rising `sclk` while `scs_n` is low, sent most significant bit first. Bits 31..20 are the header, bits 19..16 are the address and bits 15..0 are the data. A frame with header 12'h001 (eleven zeros sent first, then a one) writes its data to the register its address selects: 1 is `cfg_reg`, 2 is `ofs_reg` and 3 is `fs_reg`. The other two registers keep their values.
- R3: Each completed write to address 1, 2 or 3 raises `wr_stb` for exactly one system clock cycle, with `wr_addr` equal to the address written.
- R4: A well-formed frame to address 0 or to any address from 4 to 15 changes no register and raises no strobe.
- R5: If the first 12 bits of a frame are not 12'h001, that frame writes nothing. Every later frame sent while `scs_n` stays low is also ignored. The first frame after `scs_n` is deasserted and asserted again is accepted.
- R6: A new frame may start on the 33rd rising `sclk` edge with no deassertion of `scs_n`. Several frames sent back to back each perform their write.
- R7: Deasserting `scs_n` before the 32nd bit abandons the partial frame without any write. The next frame is counted from its first bit.
- R8: While `ext_mode` is low, serial activity writes nothing and raises no strobe, and any partial frame is dropped. After `ext_mode` returns high with `scs_n` still low, a new frame is accepted from its first bit.
- R9: Rising `sclk` edges that occur while `scs_n` is high change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| ext_mode | input | 1 | Port enable; serial writes are honoured only while high |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| scs_n | input | 1 | Active-low serial select |
| cfg_reg | output | 16 | Configuration register (address 1) |
| ofs_reg | output | 16 | Input offset register (address 2) |
| fs_reg | output | 16 | Full-scale adjust register (address 3) |
| wr_stb | output | 1 | One-cycle pulse on each completed mapped write |
| wr_addr | output | 4 | Address of the most recent mapped write |

## Verification
The serial pins pass through two synchronizer flops and an edge-detect flop, then the deframer register and the register bank. As a result, a register and its strobe change four system cycles after the rising `sclk` edge that carries bit 0. The bench holds each `sclk` level for four cycles and waits eight more cycles after the final falling edge, so every check falls well after the result is due and before the next frame starts. Strobes are counted by a monitor on the falling clock edge, which also flags any strobe wider than one cycle. The register values and strobe counts are compared with a model that the bench updates from the address and data it sent.

// File: rtl/regport_pkg.sv
package regport_pkg;
  localparam int DATA_W   = 16;
  localparam int ADDR_W   = 4;
  localparam int HDR_W    = 12;
  localparam int FRAME_W  = HDR_W + ADDR_W + DATA_W;
  localparam int FIELD_W  = ADDR_W + DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W);
  localparam logic [HDR_W-1:0] HDR_PAT = 12'h001;

  localparam int NUM_REGS  = 3;
  localparam int BASE_ADDR = 1;

  localparam logic [DATA_W-1:0] CFG_DEFAULT = 16'h00C0;
  localparam logic [DATA_W-1:0] OFS_DEFAULT = 16'h0000;
  localparam logic [DATA_W-1:0] FS_DEFAULT  = 16'h8000;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/regport_sync.sv
module regport_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= RST_VAL;
    else     stg[0] <= d;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[i] <= RST_VAL;
        else     stg[i] <= stg[i-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/regport_deframe.sv
module regport_deframe
  import regport_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   en,
  input  logic   sel,
  input  logic   sck,
  input  logic   sd,
  output frame_t frm
);
  logic               sck_prev;
  logic               rise;
  logic [CNT_W-1:0]   cnt;
  logic               drop;
  logic [FIELD_W-2:0] sh;
  logic [FIELD_W-1:0] word;

  assign rise = sck & ~sck_prev;
  assign word = {sh, sd};

  always_ff @(posedge clk) begin
    if (rst) sck_prev <= 1'b0;
    else     sck_prev <= sck;
  end

  always_ff @(posedge clk) begin
    if (rst || !en || !sel) begin
      cnt      <= '0;
      drop     <= 1'b0;
      sh       <= '0;
      frm.vld  <= 1'b0;
      if (rst) begin
        frm.addr <= '0;
        frm.data <= '0;
      end
    end else begin
      frm.vld <= 1'b0;
      if (rise && !drop) begin
        sh <= word[FIELD_W-2:0];
        if (cnt == CNT_W'(HDR_W-1) && word[HDR_W-1:0] != HDR_PAT) begin
          drop <= 1'b1;
          cnt  <= '0;
        end else if (cnt == CNT_W'(FRAME_W-1)) begin
          frm.vld  <= 1'b1;
          frm.addr <= word[FIELD_W-1:DATA_W];
          frm.data <= word[DATA_W-1:0];
          cnt      <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/regport_bank.sv
module regport_bank
  import regport_pkg::*;
#(
  parameter logic [NUM_REGS*DATA_W-1:0] DEFAULTS = {FS_DEFAULT, OFS_DEFAULT, CFG_DEFAULT}
) (
  input  logic                             clk,
  input  logic                             rst,
  input  frame_t                           frm,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs_q,
  output logic                             stb,
  output logic [ADDR_W-1:0]                stb_addr
);
  logic [NUM_REGS-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      assign hit[i] = frm.vld && (frm.addr == ADDR_W'(BASE_ADDR + i));
      always_ff @(posedge clk) begin
        if (rst)         regs_q[i] <= DEFAULTS[i*DATA_W +: DATA_W];
        else if (hit[i]) regs_q[i] <= frm.data;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      stb      <= 1'b0;
      stb_addr <= '0;
    end else begin
      stb <= |hit;
      if (|hit) stb_addr <= frm.addr;
    end
  end
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import regport_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] CFG_DEF     = CFG_DEFAULT,
  parameter logic [DATA_W-1:0] OFS_DEF     = OFS_DEFAULT,
  parameter logic [DATA_W-1:0] FS_DEF      = FS_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ext_mode,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              scs_n,
  output logic [DATA_W-1:0] cfg_reg,
  output logic [DATA_W-1:0] ofs_reg,
  output logic [DATA_W-1:0] fs_reg,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr
);
  logic [2:0]                      pins_s;
  frame_t                          frm;
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scs_n, sclk, sdata}),
    .q   (pins_s)
  );

  regport_deframe u_deframe (
    .clk (clk),
    .rst (rst),
    .en  (ext_mode),
    .sel (~pins_s[2]),
    .sck (pins_s[1]),
    .sd  (pins_s[0]),
    .frm (frm)
  );

  regport_bank #(.DEFAULTS({FS_DEF, OFS_DEF, CFG_DEF})) u_bank (
    .clk      (clk),
    .rst      (rst),
    .frm      (frm),
    .regs_q   (regs_q),
    .stb      (wr_stb),
    .stb_addr (wr_addr)
  );

  assign cfg_reg = regs_q[0];
  assign ofs_reg = regs_q[1];
  assign fs_reg  = regs_q[2];
endmodule

// File: rtl/regport_chk.sv
module regport_chk
  import regport_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              ext_mode,
  input logic [DATA_W-1:0] cfg_reg,
  input logic [DATA_W-1:0] ofs_reg,
  input logic [DATA_W-1:0] fs_reg,
  input logic              wr_stb,
  input logic [ADDR_W-1:0] wr_addr
);
  logic past_rst = 1'b0;
  always_ff @(posedge clk) past_rst <= rst;

  // R1: defaults right after reset release
  assert_reset_defaults_R1: assert property (@(posedge clk)
    (past_rst && !rst) |-> (cfg_reg == CFG_DEFAULT && ofs_reg == OFS_DEFAULT &&
                            fs_reg == FS_DEFAULT && !wr_stb));

  // R2: a register moves only together with its own strobe
  assert_cfg_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!past_rst && cfg_reg != $past(cfg_reg)) |-> (wr_stb && wr_addr == 4'd1));
  assert_ofs_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!past_rst && ofs_reg != $past(ofs_reg)) |-> (wr_stb && wr_addr == 4'd2));
  assert_fs_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!past_rst && fs_reg != $past(fs_reg)) |-> (wr_stb && wr_addr == 4'd3));

  // R3: strobe lasts one cycle
  assert_stb_single_R3: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R4: strobe never reports a reserved address
  assert_stb_mapped_R4: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> (wr_addr >= 4'd1 && wr_addr <= 4'd3));

  // R8: no strobe follows a cycle with the port disabled
  assert_mode_gate_R8: assert property (@(posedge clk) disable iff (rst)
    !ext_mode |=> !wr_stb);
endmodule

bind serial_regport regport_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .ext_mode (ext_mode),
  .cfg_reg  (cfg_reg),
  .ofs_reg  (ofs_reg),
  .fs_reg   (fs_reg),
  .wr_stb   (wr_stb),
  .wr_addr  (wr_addr)
);

// File: tb/tb_serial_regport.sv
module tb_serial_regport;
  localparam int HALF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ext_mode = 1'b1;
  logic        sclk = 1'b0;
  logic        sdata = 1'b0;
  logic        scs_n = 1'b1;
  logic [15:0] cfg_reg, ofs_reg, fs_reg;
  logic        wr_stb;
  logic [3:0]  wr_addr;

  int total = 0;
  int bad = 0;
  int stb_cnt = 0;
  int wide_cnt = 0;
  logic prev_stb = 1'b0;
  logic [3:0] last_addr = 4'd0;

  logic [15:0] e_cfg, e_ofs, e_fs;
  int e_stb;
  logic [3:0] e_addr;

  always #5 clk = ~clk;

  serial_regport dut (
    .clk(clk), .rst(rst), .ext_mode(ext_mode), .sclk(sclk), .sdata(sdata),
    .scs_n(scs_n), .cfg_reg(cfg_reg), .ofs_reg(ofs_reg), .fs_reg(fs_reg),
    .wr_stb(wr_stb), .wr_addr(wr_addr)
  );

  always @(negedge clk) begin
    if (rst) begin
      stb_cnt  <= 0;
      prev_stb <= 1'b0;
    end else begin
      if (wr_stb) begin
        stb_cnt   <= stb_cnt + 1;
        last_addr <= wr_addr;
        if (prev_stb) wide_cnt <= wide_cnt + 1;
      end
      prev_stb <= wr_stb;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(logic ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    tick(8);
    check(cfg_reg == e_cfg, req, "cfg_reg", int'(cfg_reg), int'(e_cfg));
    check(ofs_reg == e_ofs, req, "ofs_reg", int'(ofs_reg), int'(e_ofs));
    check(fs_reg == e_fs, req, "fs_reg", int'(fs_reg), int'(e_fs));
    check(stb_cnt == e_stb, req, "strobe count", stb_cnt, e_stb);
    check(last_addr == e_addr, req, "strobe addr", int'(last_addr), int'(e_addr));
    check(wide_cnt == 0, req, "wide strobe", wide_cnt, 0);
  endtask

  task automatic shift_bit(logic b);
    sdata = b;
    tick(HALF);
    sclk = 1'b1;
    tick(HALF);
    sclk = 1'b0;
  endtask

  task automatic send(logic [31:0] w, int nbits);
    for (int i = 31; i > 31 - nbits; i--) shift_bit(w[i]);
  endtask

  function automatic logic [31:0] frame(logic [11:0] h, logic [3:0] a, logic [15:0] d);
    return {h, a, d};
  endfunction

  function automatic logic [15:0] pat(int a, int k);
    return 16'((a * 16'h1357) ^ (k * 16'h2E41) ^ 16'h5A0F);
  endfunction

  task automatic model(logic [3:0] a, logic [15:0] d);
    case (a)
      4'd1: e_cfg = d;
      4'd2: e_ofs = d;
      4'd3: e_fs  = d;
      default: ;
    endcase
    if (a >= 4'd1 && a <= 4'd3) begin
      e_stb++;
      e_addr = a;
    end
  endtask

  task automatic select(logic on);
    scs_n = ~on;
    tick(8);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    e_cfg = 16'h00C0; e_ofs = 16'h0000; e_fs = 16'h8000; e_stb = 0; e_addr = 4'd0;
    tick(5);
    rst = 1'b0;
    tick(1);
    // R1: reset state
    check_all("R1");

    // R2 R3 R4: sweep every address with a well-formed frame
    for (int a = 0; a < 16; a++) begin
      select(1'b1);
      send(frame(12'h001, 4'(a), pat(a, 1)), 32);
      model(4'(a), pat(a, 1));
      select(1'b0);
      check_all((a >= 1 && a <= 3) ? "R2_R3" : "R4");
    end

    // R6: back-to-back frames under one select
    select(1'b1);
    for (int k = 0; k < 6; k++) begin
      send(frame(12'h001, 4'(1 + k % 3), pat(k, 7)), 32);
      model(4'(1 + k % 3), pat(k, 7));
    end
    check_all("R6");
    select(1'b0);

    // R5: each single-bit header error, then a good frame under the same select
    for (int b = 0; b < 12; b++) begin
      select(1'b1);
      send(frame(12'h001 ^ (12'h1 << b), 4'd2, pat(b, 3)), 32);
      send(frame(12'h001, 4'd3, pat(b, 4)), 32);
      check_all("R5");
      select(1'b0);
      select(1'b1);
      send(frame(12'h001, 4'(1 + b % 3), pat(b, 5)), 32);
      model(4'(1 + b % 3), pat(b, 5));
      select(1'b0);
      check_all("R5");
    end

    // R7: select released mid-frame
    for (int n = 1; n < 32; n += 6) begin
      select(1'b1);
      send(frame(12'h001, 4'd1, 16'hDEAD), n);
      select(1'b0);
      check_all("R7");
      select(1'b1);
      send(frame(12'h001, 4'd2, pat(n, 9)), 32);
      model(4'd2, pat(n, 9));
      select(1'b0);
      check_all("R7");
    end

    // R8: port disabled
    ext_mode = 1'b0;
    tick(2);
    select(1'b1);
    send(frame(12'h001, 4'd1, 16'hBEEF), 32);
    send(frame(12'h001, 4'd3, 16'hBEEF), 32);
    select(1'b0);
    check_all("R8");
    ext_mode = 1'b1;
    tick(2);
    // R8: disable mid-frame, then resume under the same select
    select(1'b1);
    send(frame(12'h001, 4'd1, 16'h1234), 20);
    ext_mode = 1'b0;
    tick(4);
    ext_mode = 1'b1;
    tick(4);
    send(frame(12'h001, 4'd3, 16'h4321), 32);
    model(4'd3, 16'h4321);
    select(1'b0);
    check_all("R8");

    // R9: clock edges while deselected
    send(frame(12'h001, 4'd1, 16'hCAFE), 32);
    send(frame(12'h001, 4'd2, 16'hCAFE), 32);
    check_all("R9");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule